// File: doc/BRIEF.md
# Flash Command Interface Controller

This block models the command side of a NOR-style flash device as synchronous logic. A small register-backed array is split into equal blocks. Bus write cycles are decoded as commands. A write state machine then carries out word programs and block erases, and each of these operations holds the device busy for a count of clock cycles set by a parameter. Software can poll a status byte, or it can watch a ready output, to learn when an operation has finished and whether it failed.

A block erase can be paused. While it is paused, other blocks can still be read and programmed. The block being erased stays unreadable and cannot be written. A resume command continues the erase from the point where it stopped. Programming can only clear bits, and it does nothing unless the programming supply is reported valid. Block 0 is the boot block, and it is locked while the write-protect input is high.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset every word reads 0xFFFF, the interface is in array-read mode, ready_o is 1 and the status byte is 0x80.
- R2: Command bytes are taken from wdata_i[7:0]. A program is two writes: first 0x40 (0x10 is also accepted), then a write carrying the target address and data. After a program or any other status-producing command, reads return the status byte in bits [7:0] with the upper bits zero. This continues until 0xFF selects array reads again. 0x70 selects status reads. rdata_o is loaded on the rising edge where re_i is high and holds its value otherwise.
- R3: Status bit 7 is 1 when ready and 0 when busy, and ready_o always equals it. A program keeps ready_o low for exactly PROG_CYC samples, starting with the first falling edge after the data write. While a program is busy, all writes are ignored.
- R4: A program stores the old word ANDed with the data. Writing a 1 over a stored 0 does not set error bit 4.
- R5: If vpp_ok_i is 0 at the data write, status bits 3 and 4 are set. The array does not change, and ready_o never goes low.
- R6: With wp_i high, a program to block 0 sets status bits 1 and 4 and leaves the array unchanged. Programs to other blocks go ahead as normal. The error bits 5, 4, 3 and 1 stay set until the command 0x50 clears them.
- R7: The command 0x20 followed by 0xD0 erases the block that holds the confirm address, setting all of its words to 0xFFFF after ERASE_CYC busy samples. Other blocks do not change. If the erase is refused because vpp_ok_i is low, bits 3 and 5 are set. If it is refused because of write protect on block 0, bits 1 and 5 are set.
- R8: If 0x20 is followed by any byte other than 0xD0, status bits 4 and 5 are set and no erase starts.
- R9: The command 0xB0 during an erase pauses it after SUSP_LAT cycles, and the status then shows bits 7 and 6 both at 1. The erase does not advance while it is paused. The command 0xD0 then clears bits 6 and 7, and the erase completes once its total busy time reaches ERASE_CYC.
- R10: While an erase is paused, a program to another block reads status bit 7 as 0 and bit 6 as 1. A resume written while that program is busy has no effect.
- R11: While an erase is paused, an array read of the paused block returns the status byte. A program to that block sets bit 4 and does not change its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Bus write strobe, one cycle per write |
| re_i | input | 1 | Bus read strobe |
| addr_i | input | AW | Word address; the upper bits select the block |
| wdata_i | input | DW | Write data; the low byte carries the command |
| wp_i | input | 1 | Write protect for block 0 |
| vpp_ok_i | input | 1 | Programming supply valid |
| rdata_o | output | DW | Registered read data (array word or status byte) |
| ready_o | output | 1 | High when no program or running erase is active |

## Verification
Read data is due on the first falling edge after the rising edge where re_i was high. The bench's read task drives re_i on one falling edge and samples rdata_o on the next. Busy lengths are measured by counting the samples at which ready_o is low, starting at the falling edge that follows the launching write. Under this counting a program gives PROG_CYC, a suspend gives SUSP_LAT, and the part of an erase left after a resume gives ERASE_CYC minus the samples already run, minus any samples used up by reads. Every check samples at a falling edge, never on the active edge.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;
  localparam logic [7:0] CMD_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] CMD_READ_STATUS = 8'h70;
  localparam logic [7:0] CMD_CLEAR_STAT  = 8'h50;
  localparam logic [7:0] CMD_PROG_SETUP  = 8'h40;
  localparam logic [7:0] CMD_PROG_ALT    = 8'h10;
  localparam logic [7:0] CMD_ERASE_SETUP = 8'h20;
  localparam logic [7:0] CMD_CONFIRM     = 8'hD0;
  localparam logic [7:0] CMD_SUSPEND     = 8'hB0;

  typedef enum logic [1:0] {
    PEND_NONE,
    PEND_PROG,
    PEND_ERASE
  } pend_e;
endpackage

// File: rtl/fcc_timer.sv
module fcc_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  input  logic         en_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= val_i;
    else if (en_i && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/fcc_array.sv
module fcc_array #(
  parameter int unsigned BLOCK_WORDS = 8,
  parameter int unsigned WORDS       = 32,
  parameter int unsigned DW          = 16,
  parameter int unsigned AW          = 5,
  parameter int unsigned BIW         = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [AW-1:0]  raddr_i,
  output logic [DW-1:0]  rdata_o,
  input  logic           wr_i,
  input  logic [AW-1:0]  waddr_i,
  input  logic [DW-1:0]  wdata_i,
  input  logic           er_i,
  input  logic [BIW-1:0] er_blk_i
);
  logic [DW-1:0] mem_q [WORDS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WORDS; i++) mem_q[i] <= '1;
    end else begin
      for (int i = 0; i < WORDS; i++) begin
        if (er_i && (i / BLOCK_WORDS) == int'(er_blk_i))
          mem_q[i] <= '1;
        else if (wr_i && AW'(i) == waddr_i)
          mem_q[i] <= mem_q[i] & wdata_i;   // cells only move 1 -> 0
      end
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int unsigned BLOCKS      = 4,
  parameter int unsigned BLOCK_WORDS = 8,
  parameter int unsigned DW          = 16,
  parameter int unsigned PROG_CYC    = 8,
  parameter int unsigned ERASE_CYC   = 64,
  parameter int unsigned SUSP_LAT    = 2,
  parameter int unsigned AW          = $clog2(BLOCKS * BLOCK_WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          wp_i,
  input  logic          vpp_ok_i,
  output logic [DW-1:0] rdata_o,
  output logic          ready_o
);
  localparam int unsigned WORDS = BLOCKS * BLOCK_WORDS;
  localparam int unsigned OW    = $clog2(BLOCK_WORDS);
  localparam int unsigned BIW   = AW - OW;
  localparam int unsigned MAXA  = (ERASE_CYC > PROG_CYC) ? ERASE_CYC : PROG_CYC;
  localparam int unsigned MAXC  = (MAXA > SUSP_LAT) ? MAXA : SUSP_LAT;
  localparam int unsigned TW    = $clog2(MAXC + 1);
  localparam logic [TW-1:0] PROG_LD  = TW'(PROG_CYC - 1);
  localparam logic [TW-1:0] ERASE_LD = TW'(ERASE_CYC - 1);
  localparam logic [TW-1:0] SUSP_LD  = TW'(SUSP_LAT - 1);

  function automatic logic [BIW-1:0] blk_of(input logic [AW-1:0] a);
    return a[AW-1:OW];
  endfunction

  pend_e pend_q, pend_d;
  logic rd_array_q, rd_array_d;
  logic prog_busy_q, prog_busy_d;
  logic [AW-1:0] prog_addr_q, prog_addr_d;
  logic [DW-1:0] prog_data_q, prog_data_d;
  logic erase_act_q, erase_act_d;
  logic [BIW-1:0] erase_blk_q, erase_blk_d;
  logic susp_pend_q, susp_pend_d, susp_q, susp_d;
  logic err_erase_q, err_prog_q, err_vpp_q, err_wp_q;
  logic err_erase_d, err_prog_d, err_vpp_d, err_wp_d;
  logic prog_start, erase_start, susp_start;
  logic prog_last, erase_last, susp_last;
  logic prog_done, erase_done, susp_done, erase_run;
  logic [7:0] cmd, status;
  logic [DW-1:0] arr_rdata;
  logic show_array;

  assign cmd        = wdata_i[7:0];
  assign erase_run  = erase_act_q & ~susp_q;
  assign prog_done  = prog_busy_q & prog_last;
  assign erase_done = erase_run & erase_last;
  assign susp_done  = susp_pend_q & susp_last;
  assign ready_o    = ~(prog_busy_q | erase_run);
  assign status     = {ready_o, susp_q, err_erase_q, err_prog_q, err_vpp_q, 1'b0, err_wp_q, 1'b0};

  always_comb begin
    pend_d      = pend_q;      rd_array_d  = rd_array_q;
    prog_busy_d = prog_busy_q; prog_addr_d = prog_addr_q; prog_data_d = prog_data_q;
    erase_act_d = erase_act_q; erase_blk_d = erase_blk_q;
    susp_pend_d = susp_pend_q; susp_d      = susp_q;
    err_erase_d = err_erase_q; err_prog_d  = err_prog_q;
    err_vpp_d   = err_vpp_q;   err_wp_d    = err_wp_q;
    prog_start  = 1'b0; erase_start = 1'b0; susp_start = 1'b0;

    if (prog_done) prog_busy_d = 1'b0;
    if (erase_done) begin
      erase_act_d = 1'b0;
      susp_pend_d = 1'b0;
    end else if (susp_done) begin
      susp_pend_d = 1'b0;
      susp_d      = 1'b1;
    end

    if (we_i && !prog_busy_q) begin
      unique case (pend_q)
        PEND_PROG: begin
          pend_d = PEND_NONE; rd_array_d = 1'b0;
          if (!vpp_ok_i) begin
            err_vpp_d = 1'b1; err_prog_d = 1'b1;
          end else if (wp_i && blk_of(addr_i) == '0) begin
            err_wp_d = 1'b1; err_prog_d = 1'b1;
          end else if (erase_act_q && blk_of(addr_i) == erase_blk_q) begin
            err_prog_d = 1'b1;   // paused block stays untouched
          end else begin
            prog_busy_d = 1'b1; prog_start = 1'b1;
            prog_addr_d = addr_i; prog_data_d = wdata_i;
          end
        end
        PEND_ERASE: begin
          pend_d = PEND_NONE; rd_array_d = 1'b0;
          if (cmd != CMD_CONFIRM) begin
            err_erase_d = 1'b1; err_prog_d = 1'b1;
          end else if (!vpp_ok_i) begin
            err_erase_d = 1'b1; err_vpp_d = 1'b1;
          end else if (wp_i && blk_of(addr_i) == '0) begin
            err_erase_d = 1'b1; err_wp_d = 1'b1;
          end else begin
            erase_act_d = 1'b1; erase_start = 1'b1;
            erase_blk_d = blk_of(addr_i);
          end
        end
        default: begin
          if (erase_run) begin
            if (cmd == CMD_READ_STATUS) rd_array_d = 1'b0;
            else if (cmd == CMD_SUSPEND && !susp_pend_q && !erase_done) begin
              susp_pend_d = 1'b1; susp_start = 1'b1; rd_array_d = 1'b0;
            end
          end else begin
            case (cmd)
              CMD_READ_ARRAY:  rd_array_d = 1'b1;
              CMD_READ_STATUS: rd_array_d = 1'b0;
              CMD_CLEAR_STAT: begin
                err_erase_d = 1'b0; err_prog_d = 1'b0;
                err_vpp_d   = 1'b0; err_wp_d   = 1'b0;
              end
              CMD_PROG_SETUP, CMD_PROG_ALT: begin
                pend_d = PEND_PROG; rd_array_d = 1'b0;
              end
              CMD_ERASE_SETUP: if (!susp_q) begin
                pend_d = PEND_ERASE; rd_array_d = 1'b0;
              end
              CMD_CONFIRM: if (susp_q) begin
                susp_d = 1'b0; rd_array_d = 1'b0;
              end
              default: ;
            endcase
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= PEND_NONE; rd_array_q <= 1'b1;
      prog_busy_q <= 1'b0; prog_addr_q <= '0; prog_data_q <= '0;
      erase_act_q <= 1'b0; erase_blk_q <= '0;
      susp_pend_q <= 1'b0; susp_q <= 1'b0;
      err_erase_q <= 1'b0; err_prog_q <= 1'b0; err_vpp_q <= 1'b0; err_wp_q <= 1'b0;
    end else begin
      pend_q <= pend_d; rd_array_q <= rd_array_d;
      prog_busy_q <= prog_busy_d; prog_addr_q <= prog_addr_d; prog_data_q <= prog_data_d;
      erase_act_q <= erase_act_d; erase_blk_q <= erase_blk_d;
      susp_pend_q <= susp_pend_d; susp_q <= susp_d;
      err_erase_q <= err_erase_d; err_prog_q <= err_prog_d;
      err_vpp_q <= err_vpp_d; err_wp_q <= err_wp_d;
    end
  end

  fcc_timer #(.W(TW)) u_prog_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(prog_start), .val_i(PROG_LD),
    .en_i(prog_busy_q), .last_o(prog_last));
  fcc_timer #(.W(TW)) u_erase_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(erase_start), .val_i(ERASE_LD),
    .en_i(erase_run), .last_o(erase_last));
  fcc_timer #(.W(TW)) u_susp_tmr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(susp_start), .val_i(SUSP_LD),
    .en_i(susp_pend_q), .last_o(susp_last));

  fcc_array #(.BLOCK_WORDS(BLOCK_WORDS), .WORDS(WORDS), .DW(DW), .AW(AW), .BIW(BIW)) u_array (
    .clk_i(clk_i), .rst_ni(rst_ni), .raddr_i(addr_i), .rdata_o(arr_rdata),
    .wr_i(prog_done), .waddr_i(prog_addr_q), .wdata_i(prog_data_q),
    .er_i(erase_done), .er_blk_i(erase_blk_q));

  assign show_array = rd_array_q && !prog_busy_q && !erase_run &&
                      !(susp_q && blk_of(addr_i) == erase_blk_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_o <= '0;
    else if (re_i) rdata_o <= show_array ? arr_rdata : DW'(status);
  end
endmodule

// File: rtl/fcc_checker.sv
module fcc_checker
  import flash_cmd_pkg::*;
#(
  parameter int unsigned DW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          we_i,
  input logic          re_i,
  input logic [7:0]    cmd_i,
  input logic [DW-1:0] rdata_i,
  input logic          ready_i,
  input logic          rd_array_i,
  input logic          prog_busy_i,
  input logic          erase_act_i,
  input logic          erase_run_i,
  input logic          susp_i,
  input logic          err_prog_i
);
  AST_READY_IN_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    re_i && !rd_array_i |=> rdata_i[7] == $past(ready_i)); // R3
  AST_READ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_i)); // R2
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_prog_i && !(we_i && cmd_i == CMD_CLEAR_STAT) |=> err_prog_i); // R6
  AST_SUSP_IN_ERASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_i |-> erase_act_i); // R9
  AST_SUSP_PERSISTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    susp_i && !we_i |=> susp_i); // R9
  AST_SINGLE_OP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    prog_busy_i |-> !erase_run_i); // R10
endmodule

bind flash_cmd_ctrl fcc_checker #(.DW(DW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .re_i(re_i), .cmd_i(wdata_i[7:0]),
  .rdata_i(rdata_o), .ready_i(ready_o), .rd_array_i(rd_array_q),
  .prog_busy_i(prog_busy_q), .erase_act_i(erase_act_q), .erase_run_i(erase_run),
  .susp_i(susp_q), .err_prog_i(err_prog_q));

// File: tb/tb_flash_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_flash_cmd_ctrl;
  localparam int unsigned BLOCKS = 4, BLOCK_WORDS = 8, DW = 16;
  localparam int unsigned PROG_CYC = 8, ERASE_CYC = 64, SUSP_LAT = 2;
  localparam int unsigned WORDS = BLOCKS * BLOCK_WORDS;
  localparam int unsigned AW = $clog2(WORDS);
  localparam int K_RUN = 10;

  logic clk_i = 1'b0, rst_ni = 1'b0, we_i = 1'b0, re_i = 1'b0;
  logic wp_i = 1'b0, vpp_ok_i = 1'b1;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic ready_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [DW-1:0] mdl [WORDS];

  always #2.5 clk_i = ~clk_i;

  flash_cmd_ctrl #(.BLOCKS(BLOCKS), .BLOCK_WORDS(BLOCK_WORDS), .DW(DW),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .SUSP_LAT(SUSP_LAT)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .re_i(re_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .wp_i(wp_i), .vpp_ok_i(vpp_ok_i), .rdata_o(rdata_o), .ready_o(ready_o));

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // tasks enter and leave on a falling edge
  task automatic wr(input int a, input logic [DW-1:0] d);
    addr_i = AW'(a); wdata_i = d; we_i = 1'b1;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic cmd(input logic [7:0] c, input int a = 0);
    wr(a, DW'(c));
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    addr_i = AW'(a); re_i = 1'b1;
    @(negedge clk_i);
    re_i = 1'b0;
    d = rdata_o;
  endtask

  task automatic wait_rdy(output int n);
    n = 0;
    while (!ready_o && n < 10000) begin
      n++;
      @(negedge clk_i);
    end
  endtask

  task automatic prog(input int a, input logic [DW-1:0] d, input logic [7:0] code);
    cmd(code);
    wr(a, d);
  endtask

  function automatic logic [7:0] exp_prog_st(input bit v, input bit w, input int a);
    if (!v) return 8'h98;
    if (w && (a / BLOCK_WORDS) == 0) return 8'h92;
    return 8'h80;
  endfunction

  initial begin
    repeat (150000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [DW-1:0] d;
    int n;
    void'($urandom(32'd1357));
    for (int i = 0; i < WORDS; i++) mdl[i] = '1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    chk(ready_o, 1, "R1 ready after reset");
    rd(0, d);  chk(d, 16'hFFFF, "R1 word 0 erased");
    rd(31, d); chk(d, 16'hFFFF, "R1 last word erased");
    cmd(8'h70); rd(0, d); chk(d, 16'h0080, "R1 status after reset");

    // R2/R3/R4 basic program
    prog(9, 16'hA5C3, 8'h40);
    chk(ready_o, 0, "R3 busy after data write");
    wait_rdy(n); chk(n, PROG_CYC, "R3 program busy length");
    rd(9, d); chk(d, 16'h0080, "R2 status read after program");
    cmd(8'hFF); rd(9, d); chk(d, 16'hA5C3, "R4 programmed word");
    prog(9, 16'h5AFF, 8'h10);
    wait_rdy(n); chk(n, PROG_CYC, "R2 alternate setup code");
    rd(0, d); chk(d, 16'h0080, "R4 no error for 1 over 0");
    cmd(8'hFF); rd(9, d); chk(d, 16'h00C3, "R4 AND of old and new");

    // R5 supply low
    vpp_ok_i = 1'b0;
    prog(20, 16'h0000, 8'h40);
    chk(ready_o, 1, "R5 no busy when supply low");
    rd(0, d); chk(d, 16'h0098, "R5 bits 3 and 4");
    vpp_ok_i = 1'b1;
    cmd(8'h70); rd(0, d); chk(d, 16'h0098, "R6 error sticky");
    cmd(8'h50); rd(0, d); chk(d, 16'h0080, "R6 clear status");
    cmd(8'hFF); rd(20, d); chk(d, 16'hFFFF, "R5 array unchanged");

    // R6 write protect
    wp_i = 1'b1;
    prog(3, 16'h0000, 8'h40);
    rd(0, d); chk(d, 16'h0092, "R6 bits 1 and 4 on boot block");
    cmd(8'h50);
    prog(17, 16'h1234, 8'h40);
    wait_rdy(n); chk(n, PROG_CYC, "R6 other block programs under protect");
    cmd(8'hFF); rd(17, d); chk(d, 16'h1234, "R6 other block data");
    rd(3, d); chk(d, 16'hFFFF, "R6 boot word unchanged");

    // R7 refused erase of boot block
    cmd(8'h20); cmd(8'hD0, 2);
    chk(ready_o, 1, "R7 refused erase not busy");
    rd(0, d); chk(d, 16'h00A2, "R7 protect erase bits 1 and 5");
    wp_i = 1'b0;
    cmd(8'h50);

    // R8 sequence error
    cmd(8'h20); cmd(8'hFF);
    chk(ready_o, 1, "R8 no erase started");
    rd(0, d); chk(d, 16'h00B0, "R8 bits 4 and 5");
    cmd(8'h50);

    // R7 erase block 2
    cmd(8'h20); cmd(8'hD0, 16);
    wait_rdy(n); chk(n, ERASE_CYC, "R7 erase busy length");
    rd(0, d); chk(d, 16'h0080, "R7 status after erase");
    cmd(8'hFF); rd(17, d); chk(d, 16'hFFFF, "R7 block erased");
    rd(9, d); chk(d, 16'h00C3, "R7 other block kept");

    // R9/R10/R11 suspend on block 1
    cmd(8'h20); cmd(8'hD0, 8);
    for (int k = 0; k < K_RUN; k++) @(negedge clk_i);
    cmd(8'hB0);
    wait_rdy(n); chk(n, SUSP_LAT, "R9 suspend latency");
    rd(0, d); chk(d, 16'h00C0, "R9 suspended status");
    cmd(8'hFF);
    rd(27, d); chk(d, 16'hFFFF, "R11 other block readable");
    rd(9, d); chk(d, 16'h00C0, "R11 paused block reads status");
    prog(27, 16'h0F0F, 8'h40);
    rd(0, d); chk(d, 16'h0040, "R10 bit7 low bit6 high");
    cmd(8'hD0);
    wait_rdy(n);
    rd(0, d); chk(d, 16'h00C0, "R10 resume ignored while busy");
    prog(10, 16'h0000, 8'h40);
    rd(0, d); chk(d, 16'h00D0, "R11 program to paused block rejected");
    cmd(8'h50);
    cmd(8'hD0);
    chk(ready_o, 0, "R9 busy after resume");
    rd(0, d); chk(d, 16'h0000, "R9 bits 6 and 7 cleared");
    wait_rdy(n); chk(n, ERASE_CYC - (K_RUN + 1 + SUSP_LAT) - 1, "R9 erase remainder");
    cmd(8'hFF);
    rd(9, d);  chk(d, 16'hFFFF, "R9 erase completed");
    rd(10, d); chk(d, 16'hFFFF, "R11 paused block not programmed");
    rd(27, d); chk(d, 16'h0F0F, "R10 program during suspend");
    mdl[27] = 16'h0F0F;

    // random programs
    for (int it = 0; it < 40; it++) begin
      int a;
      logic [DW-1:0] dv;
      bit v, w;
      logic [7:0] st;
      a  = int'($urandom_range(WORDS - 1, 0));
      dv = DW'($urandom);
      v  = ($urandom_range(9, 0) != 0);
      w  = ($urandom_range(1, 0) != 0);
      vpp_ok_i = v; wp_i = w;
      prog(a, dv, ($urandom_range(1, 0) != 0) ? 8'h40 : 8'h10);
      st = exp_prog_st(v, w, a);
      wait_rdy(n);
      chk(n, (st == 8'h80) ? PROG_CYC : 0, "R3 random busy length");
      rd(0, d); chk(d, DW'(st), "R5 R6 random status");
      if (st == 8'h80) mdl[a] = mdl[a] & dv;
      cmd(8'h50); cmd(8'hFF);
      rd(a, d); chk(d, mdl[a], "R4 random array word");
    end
    vpp_ok_i = 1'b1; wp_i = 1'b0;
    finish_run();
  end
endmodule